// File: doc/BRIEF.md
# Two-Wire Display Memory Slave Port

This block is the serial front end of a segment LCD controller. It listens on a two-wire I2C bus and answers only to its own fixed 7-bit address. On a write transfer, the first byte after the address is either a pointer load or a control command. After a pointer load, each further byte goes into a 22-byte display memory at the pointer. The pointer then steps up by one and wraps at the end of the memory. A control command leaves the block as a one-cycle strobe for the configuration logic, and the rest of that transfer is discarded.

A host reads the memory in two steps. It first sends a write transfer that only loads the pointer. It then issues a repeated START with the read bit set. Bytes come out most significant bit first until the host withholds its acknowledge. A fast system clock oversamples both bus lines. The block never drives SDA high: it gives only an enable that pulls the line low. The LCD scan logic reads the same memory through a separate asynchronous port.

Top module: `lcd_i2c_ram_slave`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal 7'b0111111. Bit 0 of that byte selects read when 1 and write when 0. A byte with any other address is not acknowledged, and the block then ignores the bus until the next START.
- R2: The block takes SDA falling while SCL is high as START and SDA rising while SCL is high as STOP. A repeated START restarts address reception exactly as a START does.
- R3: On a write, a first byte of the form 3'b000 followed by a 5-bit value below 22 loads the pointer with that value. Each later byte is stored at the pointer, and every accepted byte is acknowledged with SDA low during the ninth clock.
- R4: The pointer advances by one after the acknowledge clock of each stored byte. It goes from 21 back to 0 and never holds a value above 21.
- R5: A first byte whose top three bits are not all zero is a command. It is acknowledged and appears on cmd_byte together with a cmd_valid pulse of exactly one clock.
- R6: Bytes that follow a command in the same transfer are acknowledged, but they change no memory and raise no further strobe.
- R7: A first byte of pointer form with a 5-bit value of 22 or more is acknowledged. It does not move the pointer, and later bytes in that transfer are discarded without a strobe.
- R8: On a read, the byte at the pointer is sent most significant bit first. The pointer advances only when the host acknowledges, with the same wrap from 21 to 0.
- R9: A host NACK ends the output and SDA is released. The pointer stays on the last byte sent, so the next read starts with that byte.
- R10: After reset the pointer is 0, SDA is released and no strobe is raised. Display memory contents survive a reset.
- R11: The SDA enable changes only just after a synchronized SCL falling edge, or on START or STOP.
- R12: disp_data shows the memory byte selected by disp_addr without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cmd_valid | output | 1 | One-cycle strobe for a command byte |
| cmd_byte | output | 8 | Command byte, valid with cmd_valid |
| disp_addr | input | 5 | Display-side memory read address |
| disp_data | output | 8 | Memory byte at disp_addr |

## Verification
The bench fills the whole memory from address 0, then starts a write at address 20 so that it runs across the wrap. Transfers whose first byte is a command or an out-of-range pointer test that the trailing bytes are still acknowledged but dropped. Foreign addresses must draw no acknowledge at all. Reads after a repeated START cross the wrap and end with a NACK; a second read without a pointer load then checks where the pointer stopped, and a reset in mid-run checks the pointer's return to zero. Seeded random pointer loads and payload lengths, checked against a byte-level model, look for misordered bits and off-by-one pointer steps.

// File: rtl/lcdi2c_pkg.sv
package lcdi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } bus_state_e;

  typedef enum logic [1:0] {
    BK_ADDR, BK_FIRST, BK_DATA, BK_SKIP
  } byte_kind_e;
endpackage

// File: rtl/lcdi2c_sync.sv
module lcdi2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  // index 1 = SCL, index 0 = SDA
  logic [1:0][STAGES-1:0] chain;
  logic [1:0] now_v, prev_v;

  always_comb begin
    for (int g = 0; g < 2; g++) now_v[g] = chain[g][STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '1;
      prev_v <= '1;
    end else begin
      chain[1] <= {chain[1][STAGES-2:0], scl_in};
      chain[0] <= {chain[0][STAGES-2:0], sda_in};
      prev_v   <= now_v;
    end
  end

  assign sda_s     = now_v[0];
  assign scl_rise  = now_v[1] & ~prev_v[1];
  assign scl_fall  = ~now_v[1] & prev_v[1];
  assign bus_start = now_v[1] & prev_v[1] & prev_v[0] & ~now_v[0];
  assign bus_stop  = now_v[1] & prev_v[1] & ~prev_v[0] & now_v[0];
endmodule

// File: rtl/lcdi2c_ram.sv
module lcdi2c_ram #(
  parameter int DEPTH = 22,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : 8'h00;
  assign rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : 8'h00;
endmodule

// File: rtl/lcd_i2c_ram_slave.sv
module lcd_i2c_ram_slave
  import lcdi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0111111,
  parameter int         RAM_BYTES   = 22,
  parameter int         SYNC_STAGES = 2,
  localparam int        PW          = $clog2(RAM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic          cmd_valid,
  output logic [7:0]    cmd_byte,
  input  logic [PW-1:0] disp_addr,
  output logic [7:0]    disp_data
);
  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(RAM_BYTES - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic is_ptr_load(input logic [7:0] b);
    return (b[7:5] == 3'b000) && (int'(b[4:0]) < RAM_BYTES);
  endfunction

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  lcdi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  bus_state_e    state;
  byte_kind_e    kind;
  logic [7:0]    shreg, txsh;
  logic [3:0]    bitcnt;
  logic          rw_rd, inc_pend, mack_ok;
  logic [PW-1:0] ptr;

  // named events for the checker
  logic byte_done, addr_hit, addr_miss, ptr_load, cmd_hit, ram_we, tx_adv;
  logic [PW-1:0] tx_addr;
  logic [7:0]    rd_tx;

  assign byte_done = (state == ST_RX) && (bitcnt == 4'd8) && scl_fall;
  assign addr_hit  = byte_done && (kind == BK_ADDR) && (shreg[7:1] == DEV_ADDR);
  assign addr_miss = byte_done && (kind == BK_ADDR) && (shreg[7:1] != DEV_ADDR);
  assign ptr_load  = byte_done && (kind == BK_FIRST) && is_ptr_load(shreg);
  assign cmd_hit   = byte_done && (kind == BK_FIRST) && (shreg[7:5] != 3'b000);
  assign ram_we    = byte_done && (kind == BK_DATA);
  assign tx_adv    = (state == ST_MACK) && scl_fall && mack_ok;
  assign tx_addr   = tx_adv ? ptr_next(ptr) : ptr;

  lcdi2c_ram #(.DEPTH(RAM_BYTES), .AW(PW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ptr), .wdata(shreg),
    .raddr_a(tx_addr), .rdata_a(rd_tx),
    .raddr_b(disp_addr), .rdata_b(disp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= BK_ADDR;
      shreg     <= '0;
      txsh      <= '0;
      bitcnt    <= '0;
      rw_rd     <= 1'b0;
      inc_pend  <= 1'b0;
      mack_ok   <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (bus_start) begin
        state    <= ST_RX;
        kind     <= BK_ADDR;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        inc_pend <= 1'b0;
      end else if (bus_stop) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        inc_pend <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              unique case (kind)
                BK_ADDR: begin
                  if (addr_hit) begin
                    rw_rd  <= shreg[0];
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                    kind   <= BK_FIRST;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                BK_FIRST: begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  if (ptr_load) begin
                    ptr  <= PW'(shreg[4:0]);
                    kind <= BK_DATA;
                  end else begin
                    kind <= BK_SKIP;
                    if (cmd_hit) begin
                      cmd_valid <= 1'b1;
                      cmd_byte  <= shreg;
                    end
                  end
                end
                BK_DATA: begin
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                  inc_pend <= 1'b1;
                end
                default: begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt   <= '0;
              inc_pend <= 1'b0;
              if (inc_pend) ptr <= ptr_next(ptr);
              if (rw_rd) begin
                state  <= ST_TX;
                txsh   <= rd_tx;
                sda_oe <= ~rd_tx[7];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 4'd7) begin
                state  <= ST_MACK;
                sda_oe <= 1'b0;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_ok) begin
                ptr    <= ptr_next(ptr);
                txsh   <= rd_tx;
                sda_oe <= ~rd_tx[7];
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_i2c_ram_slave_chk.sv
module lcd_i2c_ram_slave_chk #(
  parameter int PW   = 5,
  parameter int LAST = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          cmd_valid,
  input logic          scl_fall,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          addr_miss,
  input logic          ptr_load,
  input logic          ram_we,
  input logic [PW-1:0] ptr
);
  AST_ADDR_MISS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe); // R1

  AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> sda_oe); // R3

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) <= LAST); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr) && !$past(ptr_load)) |->
      ptr == (($past(ptr) == PW'(LAST)) ? '0 : $past(ptr) + 1'b1)); // R4

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R5

  AST_CMD_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> sda_oe); // R5

  AST_OE_AFTER_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(bus_start) || $past(bus_stop))); // R11
endmodule

bind lcd_i2c_ram_slave lcd_i2c_ram_slave_chk #(.PW(PW), .LAST(RAM_BYTES - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
  .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
  .addr_miss(addr_miss), .ptr_load(ptr_load), .ram_we(ram_we), .ptr(ptr)
);

// File: tb/lcd_i2c_ram_slave_bench.sv
module lcd_i2c_ram_slave_bench;
  localparam int N = 22;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic sda_oe, cmd_valid;
  logic [7:0] cmd_byte, disp_data;
  logic [4:0] disp_addr = '0;
  wire sda_line = msda & ~sda_oe;

  lcd_i2c_ram_slave u_lcd_i2c_ram_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .disp_addr(disp_addr), .disp_data(disp_data)
  );

  always #10 clk = ~clk;

  logic [7:0] exp_ram [N];
  logic [7:0] pay [32];
  int exp_ptr = 0;
  int n_cmp = 0, n_bad = 0;
  int cmd_cnt = 0, exp_cmd = 0;
  logic [7:0] last_cmd = '0;

  always @(negedge clk) if (rst_n && cmd_valid) begin
    cmd_cnt++;
    last_cmd = cmd_byte;
  end

  function automatic int nxt(input int p);
    return (p == N - 1) ? 0 : p + 1;
  endfunction

  function automatic logic loads_ptr(input logic [7:0] b);
    return (b[7:5] == 3'b000) && (int'(b[4:0]) < N);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wq(Q); scl = 1'b1; wq(Q); msda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; wq(Q); scl = 1'b1; wq(Q); msda = 1'b1; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
    end
    msda = 1'b1; wq(Q); scl = 1'b1; wq(Q / 2);
    ack = (sda_line == 1'b0);
    wq(Q / 2); scl = 1'b0; wq(Q);
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic give_ack);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q / 2); b[i] = sda_line; wq(Q / 2); scl = 1'b0;
    end
    wq(Q); msda = give_ack ? 1'b0 : 1'b1;
    wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q); msda = 1'b1;
  endtask

  // write transfer: first byte, then n payload bytes from pay[]
  task automatic send_write(input logic [7:0] first, input int n, input logic do_stop);
    logic ack;
    logic stored;
    bus_start();
    wr_byte(8'h7E, ack); chk("R1 address ack on write", ack, 1'b1);
    wr_byte(first, ack);  chk("R3 first byte ack", ack, 1'b1);
    stored = loads_ptr(first);
    if (stored) exp_ptr = int'(first[4:0]);
    else if (first[7:5] != 3'b000) exp_cmd++;
    for (int i = 0; i < n; i++) begin
      wr_byte(pay[i], ack);
      chk(stored ? "R3 data ack" : "R6 ignored byte still acked", ack, 1'b1);
      if (stored) begin
        exp_ram[exp_ptr] = pay[i];
        exp_ptr = nxt(exp_ptr);
      end
    end
    if (do_stop) bus_stop();
    chk("R5 R6 R7 strobe count", cmd_cnt, exp_cmd);
  endtask

  task automatic send_read(input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    wr_byte(8'h7F, ack); chk("R1 address ack on read", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      rd_byte(b, i < n - 1);
      chk("R8 read byte", b, exp_ram[exp_ptr]);
      if (i < n - 1) exp_ptr = nxt(exp_ptr);
    end
    chk("R9 SDA released after NACK", sda_oe, 1'b0);
    bus_stop();
  endtask

  task automatic disp_chk(input string req);
    for (int a = 0; a < N; a++) begin
      disp_addr = 5'(a); #1;
      chk(req, disp_data, exp_ram[a]);
    end
  endtask

  initial begin
    logic ack;
    logic [7:0] r;
    // R10: reset state
    wq(5);
    chk("R10 sda released in reset", sda_oe, 1'b0);
    chk("R10 no strobe in reset", cmd_valid, 1'b0);
    rst_n = 1'b1; wq(5);
    chk("R10 sda released after reset", sda_oe, 1'b0);

    // R3 R4 R12: fill memory from 0, full lap wraps the pointer
    for (int i = 0; i < N; i++) pay[i] = 8'(i * 7 + 3);
    send_write(8'h00, N, 1'b1);
    disp_chk("R12 display port after fill");

    // R4: write across the wrap 20,21,0,1
    pay[0] = 8'hA5; pay[1] = 8'h5A; pay[2] = 8'hC3; pay[3] = 8'h3C;
    send_write(8'h14, 4, 1'b1);
    disp_chk("R4 wrap on write");

    // R2 R8: pointer load, repeated START, read across wrap
    send_write(8'h13, 0, 1'b0);
    send_read(5);
    // R9: pointer stays on last byte sent
    send_read(2);

    // R1: foreign addresses are ignored
    bus_start();
    wr_byte(8'h70, ack); chk("R1 foreign address not acked", ack, 1'b0);
    wr_byte(8'h02, ack); chk("R1 ignored until START", ack, 1'b0);
    wr_byte(8'hEE, ack); chk("R1 ignored until START", ack, 1'b0);
    bus_stop();
    bus_start();
    wr_byte(8'h7C, ack); chk("R1 one-bit address mismatch", ack, 1'b0);
    bus_stop();
    disp_chk("R1 memory unchanged");

    // R5 R6: command, trailing bytes ignored
    pay[0] = 8'h02; pay[1] = 8'hC1; pay[2] = 8'h71;
    send_write(8'h85, 3, 1'b1);
    chk("R5 command byte", last_cmd, 8'h85);
    disp_chk("R6 memory unchanged after command");
    send_write(8'hC2, 1, 1'b1);
    chk("R5 second command byte", last_cmd, 8'hC2);

    // R7: out-of-range pointer form
    pay[0] = 8'h99; pay[1] = 8'h66;
    send_write(8'h16, 2, 1'b1);
    disp_chk("R7 memory unchanged");
    send_read(1);

    // R10: reset returns pointer to 0, memory kept
    send_write(8'h09, 0, 1'b0);
    send_read(3);
    rst_n = 1'b0; wq(4); rst_n = 1'b1; wq(4);
    exp_ptr = 0;
    send_read(2);

    // random traffic
    r = 8'($urandom(32'd2024));
    for (int k = 0; k < 10; k++) begin
      int n;
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
      send_write(8'($urandom % N), n, 1'b1);
      send_write(8'($urandom % N), 0, 1'b0);
      send_read(1 + int'($urandom % 4));
    end
    disp_chk("R3 R12 after random traffic");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule